// File: doc/BRIEF.md
# Event Queue Consumer Dispatcher

This engine drains a ring of event elements that a producer fills in memory. Each element holds a 32-bit descriptor word and a 32-bit payload word. Ownership is tracked with a wrap bit rather than a producer index. The engine keeps an expected wrap value. An element whose wrap bit still equals that value has not been written since the last lap, so draining stops there. Draining starts when `irq_i` pulses.

For each new element the engine reads memory through a fixed-latency read port. It reorders the descriptor from big-endian byte order and checks the event type. An element that comes from the local source (source bit 0), whose type is enabled and whose handler is idle, goes to that type's handler port. The engine then waits for the handler's done pulse. Elements with the source bit set are consumed without dispatch. An out-of-range type aborts the pass on the spot.

At the end of every pass, one write presents the consumer index, the wrap flag and an armed bit, protected by a nibble checksum. A pass never handles more elements than the ring holds.

Top module: `evq_drain_top`

## Requirements
- R1: After reset no handler valid, memory request, writeback or error output is active. The consumer index starts at 0 and the wrap flag at 0.
- R2: The descriptor is the high 32 bits of the 64-bit read word, stored byte-reversed, so its least significant byte sits in bits 31:24. After reordering, bit 31 is the wrap bit, bit 30 the source bit, bits 23:16 the size and bits 7:0 the type. The low 32 bits of the read word are the payload. Type, size and payload are presented unchanged on the handler port.
- R3: A pass stops, without consuming, at the first element whose wrap bit equals the engine's wrap flag.
- R4: A pass processes at most QLEN elements, then ends even if more new elements follow.
- R5: A type value of N_TYPES or more pulses `err_type_o` and ends the pass without advancing the index.
- R6: An element with source bit 1 is consumed without any handler being invoked.
- R7: An element with source bit 0 is dispatched only if `hdl_en_i` has its type's bit set and that type is not running. Otherwise `err_unhandled_o` pulses and the element is consumed.
- R8: During dispatch exactly one bit of `hdl_valid_o` is set. It stays set, with stable type, size and payload, until the matching `hdl_done_i` bit is seen.
- R9: The index advances by one per consumed element. On passing QLEN-1 it returns to 0 and the wrap flag inverts.
- R10: Each pass ends with a single-cycle `ci_wr_o` and a `ci_wdata_o` laid out as follows: index in bits 15:0, wrap flag in bit 16, armed bit 31 = 1, checksum in bits 27:24, all other bits 0. The checksum is the XOR of all eight nibbles of the word taken with the checksum field at 0.
- R11: Each element read is one single-cycle `mem_req_o` at the current index. The data is taken RD_LAT cycles after the request cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_i | input | 1 | Start a drain pass |
| mem_req_o | output | 1 | Element read request |
| mem_addr_o | output | IDX_W | Element index being read |
| mem_rdata_i | input | 64 | Raw descriptor (high) and payload (low) |
| hdl_en_i | input | N_TYPES | Per-type handler enable |
| hdl_valid_o | output | N_TYPES | Per-type dispatch request, one-hot |
| hdl_done_i | input | N_TYPES | Per-type handler completion |
| hdl_type_o | output | 8 | Type of dispatched event |
| hdl_size_o | output | 8 | Size of dispatched event |
| hdl_payload_o | output | 32 | Payload of dispatched event |
| err_type_o | output | 1 | Out-of-range type seen, pass aborted |
| err_unhandled_o | output | 1 | Local event with no ready handler |
| ci_wr_o | output | 1 | Consumer index writeback strobe |
| ci_wdata_o | output | 32 | Checksummed consumer index word |

## Verification
The hardest situation to reach is a pass that stops on its length bound rather than on ownership, since this also crosses the wrap boundary. The bench reaches it in steps. Earlier passes leave the index at 3. The bench then fills the last five slots with first-lap elements and the first three slots with second-lap elements, which carry an inverted wrap bit. A single interrupt therefore consumes exactly QLEN elements, toggles the wrap flag and writes back index 3 with wrap 1. A follow-up pass confirms that the old slot 3 now reads as not owned.

// File: rtl/evq_drain_pkg.sv
package evq_drain_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READ,
        ST_EVAL,
        ST_DISP,
        ST_WB
    } drain_state_e;

    typedef struct packed {
        logic       wrap;
        logic       src;
        logic [7:0] size;
        logic [7:0] etype;
    } evq_desc_t;

    function automatic logic [3:0] nib_xor(input logic [31:0] w);
        logic [3:0] acc;
        acc = 4'h0;
        for (int i = 0; i < 8; i++) begin
            acc = acc ^ w[i*4 +: 4];
        end
        return acc;
    endfunction

endpackage

// File: rtl/evq_desc_unpack.sv
module evq_desc_unpack
    import evq_drain_pkg::*;
(
    input  logic [31:0] raw_i,
    output evq_desc_t   desc_o
);
    localparam int NBYTES = 4;

    logic [31:0] host;

    for (genvar b = 0; b < NBYTES; b++) begin : g_swap
        assign host[b*8 +: 8] = raw_i[(NBYTES-1-b)*8 +: 8];
    end

    assign desc_o.wrap  = host[31];
    assign desc_o.src   = host[30];
    assign desc_o.size  = host[23:16];
    assign desc_o.etype = host[7:0];
endmodule

// File: rtl/evq_ci_pack.sv
module evq_ci_pack
    import evq_drain_pkg::*;
#(
    parameter int IDX_W = 3
) (
    input  logic [IDX_W-1:0] idx_i,
    input  logic             wrap_i,
    output logic [31:0]      word_o
);
    logic [31:0] base;

    always_comb begin
        base        = '0;
        base[15:0]  = 16'(idx_i);
        base[16]    = wrap_i;
        base[31]    = 1'b1;
        word_o      = base;
        word_o[27:24] = nib_xor(base);
    end
endmodule

// File: rtl/evq_drain_top.sv
module evq_drain_top
    import evq_drain_pkg::*;
#(
    parameter int QLEN    = 8,
    parameter int N_TYPES = 5,
    parameter int RD_LAT  = 2,
    parameter int IDX_W   = (QLEN > 1) ? $clog2(QLEN) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               irq_i,
    output logic               mem_req_o,
    output logic [IDX_W-1:0]   mem_addr_o,
    input  logic [63:0]        mem_rdata_i,
    input  logic [N_TYPES-1:0] hdl_en_i,
    output logic [N_TYPES-1:0] hdl_valid_o,
    input  logic [N_TYPES-1:0] hdl_done_i,
    output logic [7:0]         hdl_type_o,
    output logic [7:0]         hdl_size_o,
    output logic [31:0]        hdl_payload_o,
    output logic               err_type_o,
    output logic               err_unhandled_o,
    output logic               ci_wr_o,
    output logic [31:0]        ci_wdata_o
);
    localparam int CNT_W = $clog2(QLEN + 1);
    localparam int LAT_W = $clog2(RD_LAT + 1);

    typedef struct packed {
        drain_state_e       st;
        logic [IDX_W-1:0]   idx;
        logic               wrap;
        logic [CNT_W-1:0]   cnt;
        logic [LAT_W-1:0]   lat;
        logic [63:0]        elem;
        logic [N_TYPES-1:0] run;
        logic               err_t;
        logic               err_u;
    } regs_t;

    regs_t r_q, r_d;
    evq_desc_t desc;

    evq_desc_unpack u_unpack (
        .raw_i  (r_q.elem[63:32]),
        .desc_o (desc)
    );

    evq_ci_pack #(.IDX_W(IDX_W)) u_pack (
        .idx_i  (r_q.idx),
        .wrap_i (r_q.wrap),
        .word_o (ci_wdata_o)
    );

    logic type_ok;
    logic [N_TYPES-1:0] type_sel;

    always_comb begin
        type_ok  = 32'(desc.etype) < N_TYPES;
        type_sel = '0;
        for (int t = 0; t < N_TYPES; t++) begin
            if (32'(desc.etype) == t) type_sel[t] = 1'b1;
        end
    end

    always_comb begin
        logic advance;
        r_d       = r_q;
        r_d.err_t = 1'b0;
        r_d.err_u = 1'b0;
        advance   = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (irq_i) begin
                    r_d.st  = ST_READ;
                    r_d.cnt = '0;
                    r_d.lat = '0;
                end
            end
            ST_READ: begin
                if (32'(r_q.lat) == RD_LAT) begin
                    r_d.elem = mem_rdata_i;
                    r_d.st   = ST_EVAL;
                end else begin
                    r_d.lat = r_q.lat + 1'b1;
                end
            end
            ST_EVAL: begin
                if (desc.wrap == r_q.wrap) begin
                    r_d.st = ST_WB;
                end else if (!type_ok) begin
                    r_d.err_t = 1'b1;
                    r_d.st    = ST_WB;
                end else if (desc.src) begin
                    advance = 1'b1;
                end else if ((hdl_en_i & type_sel) != '0 &&
                             (r_q.run & type_sel) == '0) begin
                    r_d.run = r_q.run | type_sel;
                    r_d.st  = ST_DISP;
                end else begin
                    r_d.err_u = 1'b1;
                    advance   = 1'b1;
                end
            end
            ST_DISP: begin
                if ((hdl_done_i & r_q.run) != '0) begin
                    r_d.run = '0;
                    advance = 1'b1;
                end
            end
            ST_WB: begin
                r_d.st = ST_IDLE;
            end
            default: r_d.st = ST_IDLE;
        endcase

        if (advance) begin
            if (r_q.idx == IDX_W'(QLEN - 1)) begin
                r_d.idx  = '0;
                r_d.wrap = ~r_q.wrap;
            end else begin
                r_d.idx = r_q.idx + 1'b1;
            end
            r_d.cnt = r_q.cnt + 1'b1;
            r_d.lat = '0;
            r_d.st  = (32'(r_q.cnt) == QLEN - 1) ? ST_WB : ST_READ;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q      <= '0;
            r_q.st   <= ST_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign mem_req_o       = (r_q.st == ST_READ) && (r_q.lat == '0);
    assign mem_addr_o      = r_q.idx;
    assign hdl_valid_o     = (r_q.st == ST_DISP) ? r_q.run : '0;
    assign hdl_type_o      = desc.etype;
    assign hdl_size_o      = desc.size;
    assign hdl_payload_o   = r_q.elem[31:0];
    assign err_type_o      = r_q.err_t;
    assign err_unhandled_o = r_q.err_u;
    assign ci_wr_o         = (r_q.st == ST_WB);

    assert_valid_onehot_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hdl_valid_o));

    assert_valid_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (hdl_valid_o != '0 && (hdl_valid_o & hdl_done_i) == '0)
        |=> (hdl_valid_o == $past(hdl_valid_o) && $stable(hdl_payload_o) && $stable(hdl_size_o)));

    assert_req_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_o |=> !mem_req_o);

    assert_addr_range_R11: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_o |-> (32'(mem_addr_o) < QLEN));

    assert_wr_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ci_wr_o |=> !ci_wr_o);

    assert_chk_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ci_wr_o |-> (nib_xor(ci_wdata_o) == 4'h0 && ci_wdata_o[31]));

    assert_abort_noadv_R5: assert property (@(posedge clk) disable iff (!rst_n)
        err_type_o |-> (ci_wr_o && mem_addr_o == $past(mem_addr_o)));

    assert_no_disp_err_R7: assert property (@(posedge clk) disable iff (!rst_n)
        err_unhandled_o |-> hdl_valid_o == '0);
endmodule

// File: tb/tb_evq_drain_top.sv
module tb_evq_drain_top;
    localparam int QLEN    = 8;
    localparam int N_TYPES = 5;
    localparam int RD_LAT  = 2;
    localparam int IDX_W   = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic irq = 1'b0;
    logic mem_req;
    logic [IDX_W-1:0] mem_addr;
    logic [63:0] mem_rdata;
    logic [N_TYPES-1:0] hdl_en = 5'b00011;
    logic [N_TYPES-1:0] hdl_valid;
    logic [N_TYPES-1:0] hdl_done = '0;
    logic [7:0] hdl_type, hdl_size;
    logic [31:0] hdl_payload;
    logic err_type, err_unh, ci_wr;
    logic [31:0] ci_wdata;

    int n_tests = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    evq_drain_top #(.QLEN(QLEN), .N_TYPES(N_TYPES), .RD_LAT(RD_LAT), .IDX_W(IDX_W)) dut (
        .clk(clk), .rst_n(rst_n), .irq_i(irq),
        .mem_req_o(mem_req), .mem_addr_o(mem_addr), .mem_rdata_i(mem_rdata),
        .hdl_en_i(hdl_en), .hdl_valid_o(hdl_valid), .hdl_done_i(hdl_done),
        .hdl_type_o(hdl_type), .hdl_size_o(hdl_size), .hdl_payload_o(hdl_payload),
        .err_type_o(err_type), .err_unhandled_o(err_unh),
        .ci_wr_o(ci_wr), .ci_wdata_o(ci_wdata)
    );

    // memory model with fixed read latency
    logic [63:0] mem [QLEN];
    logic [63:0] pipe [RD_LAT];
    always @(posedge clk) begin
        pipe[0] <= mem_req ? mem[mem_addr] : 64'hx;
        for (int i = 1; i < RD_LAT; i++) pipe[i] <= pipe[i-1];
    end
    assign mem_rdata = pipe[RD_LAT-1];

    // handler responder: done three cycles after valid
    int wait_c = 0;
    always @(negedge clk) begin
        hdl_done <= '0;
        if (hdl_valid != '0 && hdl_done == '0) begin
            if (wait_c == 2) begin
                hdl_done <= hdl_valid;
                wait_c   <= 0;
            end else begin
                wait_c <= wait_c + 1;
            end
        end
    end

    // monitors
    int reads = 0, n_errt = 0, n_erru = 0, n_wr = 0, n_disp = 0, n_bad_hold = 0;
    logic [31:0] last_ci;
    logic [7:0] d_type [16];
    logic [7:0] d_size [16];
    logic [31:0] d_pay [16];
    logic [N_TYPES-1:0] prev_valid = '0;
    logic [31:0] prev_pay;
    always @(negedge clk) begin
        if (rst_n) begin
            if (mem_req) reads++;
            if (err_type) n_errt++;
            if (err_unh) n_erru++;
            if (ci_wr) begin n_wr++; last_ci = ci_wdata; end
            if (hdl_valid != '0 && prev_valid == '0) begin
                d_type[n_disp % 16] = hdl_type;
                d_size[n_disp % 16] = hdl_size;
                d_pay[n_disp % 16]  = hdl_payload;
                n_disp++;
            end
            if (hdl_valid != '0 && prev_valid == hdl_valid && prev_pay != hdl_payload) n_bad_hold++;
            prev_valid = hdl_valid;
            prev_pay   = hdl_payload;
        end
    end

    function automatic logic [63:0] mk(input logic w, input logic s, input logic [7:0] sz,
                                       input logic [7:0] ty, input logic [31:0] pay);
        logic [31:0] d;
        d = {w, s, 6'b0, sz, 8'b0, ty};
        return {d[7:0], d[15:8], d[23:16], d[31:24], pay};
    endfunction

    function automatic logic [31:0] exp_ci(input int idx, input logic w);
        logic [31:0] v;
        logic [3:0] c;
        v = 32'h8000_0000 | (32'(w) << 16) | 32'(idx);
        c = 4'h0;
        for (int i = 0; i < 32; i += 4) c = c ^ v[i +: 4];
        return v | (32'(c) << 24);
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    int r0, t0, u0, d0, w0;
    task automatic run_pass();
        r0 = reads; t0 = n_errt; u0 = n_erru; d0 = n_disp; w0 = n_wr;
        @(negedge clk) irq = 1'b1;
        @(negedge clk) irq = 1'b0;
        for (int i = 0; i < 2000 && n_wr == w0; i++) @(negedge clk);
        repeat (2) @(negedge clk);
        check("R10 single writeback", n_wr - w0, 1);
    endtask

    task automatic t_reset();
        check("R1 valid", 32'(hdl_valid), 0);
        check("R1 req", 32'(mem_req), 0);
        check("R1 wr", 32'(ci_wr), 0);
        check("R1 err", 32'({err_type, err_unh}), 0);
        check("R1 addr", 32'(mem_addr), 0);
    endtask

    task automatic t_empty();
        run_pass();
        check("R3 empty ci", last_ci, exp_ci(0, 1'b0));
        check("R11 empty reads", reads - r0, 1);
        check("R3 no dispatch", n_disp - d0, 0);
    endtask

    task automatic t_dispatch();
        mem[0] = mk(1'b1, 1'b0, 8'h04, 8'd0, 32'hA1B2_C3D4);
        mem[1] = mk(1'b1, 1'b1, 8'h02, 8'd1, 32'h1111_2222);
        mem[2] = mk(1'b1, 1'b0, 8'h06, 8'd3, 32'h3333_4444);
        run_pass();
        check("R6 R7 one dispatch", n_disp - d0, 1);
        check("R2 type", 32'(d_type[d0 % 16]), 0);
        check("R2 size", 32'(d_size[d0 % 16]), 4);
        check("R2 payload", d_pay[d0 % 16], 32'hA1B2_C3D4);
        check("R7 unhandled", n_erru - u0, 1);
        check("R9 ci idx3", last_ci, exp_ci(3, 1'b0));
        check("R11 reads", reads - r0, 4);
        check("R8 payload held", n_bad_hold, 0);
    endtask

    task automatic t_badtype();
        mem[3] = mk(1'b1, 1'b0, 8'h01, 8'd7, 32'hDEAD_0007);
        run_pass();
        check("R5 err type", n_errt - t0, 1);
        check("R5 no advance", last_ci, exp_ci(3, 1'b0));
        check("R5 no dispatch", n_disp - d0, 0);
    endtask

    task automatic t_bound_wrap();
        for (int i = 3; i < QLEN; i++) mem[i] = mk(1'b1, 1'b0, 8'(i), 8'd1, 32'h5000_0000 + 32'(i));
        for (int i = 0; i < 3; i++) mem[i] = mk(1'b0, 1'b1, 8'h00, 8'd0, 32'h0);
        run_pass();
        check("R4 reads bounded", reads - r0, QLEN);
        check("R9 wrap ci", last_ci, exp_ci(3, 1'b1));
        check("R7 five dispatches", n_disp - d0, 5);
        check("R2 last payload", d_pay[(d0 + 4) % 16], 32'h5000_0007);
        check("R2 last size", 32'(d_size[(d0 + 4) % 16]), 7);
        run_pass();
        check("R3 after wrap stop", last_ci, exp_ci(3, 1'b1));
        check("R3 after wrap reads", reads - r0, 1);
    endtask

    initial begin
        for (int i = 0; i < QLEN; i++) mem[i] = mk(1'b0, 1'b0, 8'h0, 8'h0, 32'h0);
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_empty();
        t_dispatch();
        t_badtype();
        t_bound_wrap();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule